// File: doc/BRIEF.md
# Three-Operand Integer ALU with Fill Shifts

This block is the integer execute stage for the three-register operation class of a 32-bit processor. Each cycle it takes a 12-bit function code and two source operands, b and c, and returns one result word with a flag that says whether the code names a defined operation. The function code is formed from the second instruction byte followed by the upper nibble of the third byte. Bits 11:8 of the code select a row, bits 7:4 select a column group, and bits 3:0 select the function within that group.

The operations cover addition and subtraction, signed and unsigned comparison, the low and high halves of a multiply, maximum and minimum, all ten non-trivial two-input bitwise functions, shifts, and rotates. Comparison does not set flags. It writes a small condition word into the destination register. Shifts can fill the vacated bits with zeros, with copies of the sign, or with ones. Any code without a defined operation returns zero and clears the legal flag. Divide and modulo codes fall into that class.

The combinational datapath feeds a single output register. Results therefore appear one clock after the operands are presented. A synchronous active-high reset clears that register.

Top module: `alu3_top`

## Requirements
- R1: While rst is high at a clock edge, the edge leaves res_o = 0 and legal_o = 0.
- R2: The result and legal flag for the inputs present at one rising edge appear on the outputs after that edge. legal_o is 1 for every code listed in R3 to R10.
- R3: Codes 0x000 and 0x001 give b + c. Codes 0x002 and 0x003 give b − c. All four wrap modulo 2^32.
- R4: Code 0x004 is a signed compare and 0x005 an unsigned compare. The result word has bit 0 set when b > c, bit 1 set when b = c, and bit 2 set when b < c. All other bits are zero.
- R5: Codes 0x006 and 0x008 give the low 32 bits of b·c. Code 0x007 gives bits 63:32 of the signed 64-bit product. Code 0x009 gives bits 63:32 of the unsigned product.
- R6: Code 0x010 gives the signed maximum and 0x011 the unsigned maximum. Code 0x012 gives the signed minimum and 0x013 the unsigned minimum.
- R7: Codes 0x020 to 0x025 give AND, OR, XOR, NAND, NOR and XNOR of b and c, in that order.
- R8: The implication forms are coded as follows: 0x026 gives ~b & c, 0x027 gives b & ~c, 0x028 gives ~b | c, and 0x029 gives b | ~c.
- R9: Codes 0x030 to 0x035 shift b by c[4:0]. Even codes shift left and odd codes shift right. The pair 0x030/0x031 fills with zeros on the left and with the sign bit on the right. The pair 0x032/0x033 fills with zeros. The pair 0x034/0x035 fills with ones. A shift amount of 0 returns b.
- R10: Code 0x036 rotates b left by c[4:0] and 0x037 rotates it right. Bits leave one end and re-enter at the other.
- R11: Every other code returns res_o = 0 with legal_o = 0. This covers 0x00A to 0x00F, 0x014 to 0x01F, 0x02A to 0x02F, and 0x038 upward, including any code with bits 11:8 non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 12 | Function code (row, group, function) |
| b_i | input | W (32) | First source operand |
| c_i | input | W (32) | Second source operand; bits 4:0 are the shift and rotate amount |
| res_o | output | W (32) | Registered result |
| legal_o | output | 1 | Registered flag, high when op_i named a defined operation |

## Verification
Every result is due exactly one rising edge after its operands are applied, because only the output register lies between the inputs and the ports. The bench drives a new code and operand pair on each falling edge and queues the expected word and flag at the same moment. It samples the outputs 2 ns after the next rising edge and checks them against the oldest queued item, so each comparison falls halfway between that edge and the following input change. The reset check samples the outputs while reset is still held, with a legal add already on the inputs.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

  localparam int OP_W = 12;

  typedef enum logic [1:0] {
    UNIT_NONE,
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT
  } unit_e;

  // Highest defined function index in each column group
  localparam logic [3:0] ROW0_LAST = 4'h9;
  localparam logic [3:0] ROW1_LAST = 4'h3;
  localparam logic [3:0] ROW2_LAST = 4'h9;
  localparam logic [3:0] ROW3_LAST = 4'h7;

  localparam logic [OP_W-1:0] OP_CMP_S = 12'h004;
  localparam logic [OP_W-1:0] OP_CMP_U = 12'h005;

  // Truth table for a bitwise function, indexed by {b_bit, c_bit}
  function automatic logic [3:0] bit_table(input logic [3:0] fn);
    case (fn)
      4'h0:    bit_table = 4'b1000; // and
      4'h1:    bit_table = 4'b1110; // or
      4'h2:    bit_table = 4'b0110; // xor
      4'h3:    bit_table = 4'b0111; // nand
      4'h4:    bit_table = 4'b0001; // nor
      4'h5:    bit_table = 4'b1001; // xnor
      4'h6:    bit_table = 4'b0010; // ~b & c
      4'h7:    bit_table = 4'b0100; // b & ~c
      4'h8:    bit_table = 4'b1011; // ~b | c
      4'h9:    bit_table = 4'b1101; // b | ~c
      default: bit_table = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/alu3_decode.sv
module alu3_decode
  import alu3_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output unit_e           unit,
  output logic            legal
);

  logic [3:0] hi_row;
  logic [3:0] grp;
  logic [3:0] fn;

  assign hi_row = op[11:8];
  assign grp    = op[7:4];
  assign fn     = op[3:0];

  always_comb begin
    unit = UNIT_NONE;
    if (hi_row == 4'h0) begin
      case (grp)
        4'h0:    if (fn <= ROW0_LAST) unit = UNIT_ARITH;
        4'h1:    if (fn <= ROW1_LAST) unit = UNIT_ARITH;
        4'h2:    if (fn <= ROW2_LAST) unit = UNIT_LOGIC;
        4'h3:    if (fn <= ROW3_LAST) unit = UNIT_SHIFT;
        default: unit = UNIT_NONE;
      endcase
    end
  end

  assign legal = (unit != UNIT_NONE);

endmodule

// File: rtl/alu3_arith.sv
module alu3_arith #(
  parameter int W = 32
) (
  input  logic         row1,
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);

  localparam int PW = 2 * W;

  // shared comparator
  logic lt_s, lt_u, eq, lt_sel, gt_sel;
  assign lt_s   = $signed(b) < $signed(c);
  assign lt_u   = b < c;
  assign eq     = (b == c);
  assign lt_sel = fn[0] ? lt_u : lt_s;
  assign gt_sel = !lt_sel && !eq;

  // add / subtract through one adder
  logic         do_sub;
  logic [W-1:0] c_inv, sum;
  assign do_sub = fn[1];
  assign c_inv  = do_sub ? ~c : c;
  assign sum    = b + c_inv + {{(W-1){1'b0}}, do_sub};

  // single signed (W+1)x(W+1) multiplier serves both signednesses
  logic                 mul_signed;
  logic signed [W:0]    eb, ec;
  logic signed [PW-1:0] prod;
  assign mul_signed = !fn[3];
  assign eb   = {mul_signed & b[W-1], b};
  assign ec   = {mul_signed & c[W-1], c};
  assign prod = eb * ec;

  // max / min
  logic [W-1:0] mx, mn;
  assign mx = lt_sel ? c : b;
  assign mn = lt_sel ? b : c;

  logic [W-1:0] cmp_word;
  assign cmp_word = {{(W-3){1'b0}}, lt_sel, eq, gt_sel};

  always_comb begin
    y = '0;
    if (row1) begin
      y = fn[1] ? mn : mx;
    end else begin
      case (fn)
        4'h0, 4'h1, 4'h2, 4'h3: y = sum;
        4'h4, 4'h5:             y = cmp_word;
        4'h6, 4'h8:             y = prod[W-1:0];
        4'h7, 4'h9:             y = prod[PW-1:W];
        default:                y = '0;
      endcase
    end
  end

  always_comb begin
    a_r4_cmp_exclusive: assert ($onehot({lt_sel, eq, gt_sel}));
    a_r6_max_not_below_min: assert (fn[0] ? (mx >= mn) : ($signed(mx) >= $signed(mn)));
  end

endmodule

// File: rtl/alu3_logic.sv
module alu3_logic
  import alu3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);

  logic [3:0] tt;
  assign tt = bit_table(fn);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = tt[{b[i], c[i]}];
  end

endmodule

// File: rtl/alu3_shift.sv
module alu3_shift #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [2:0]      fn,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    y
);

  localparam int DW = 2 * W;

  logic         go_right;
  logic [W-1:0] fill;
  logic [DW-1:0] left_src, right_src, left_sh, right_sh;

  assign go_right = fn[0];

  // fill word supplies the bits that enter from the vacated side
  always_comb begin
    case (fn[2:1])
      2'b00:   fill = go_right ? {W{b[W-1]}} : '0;
      2'b01:   fill = '0;
      2'b10:   fill = '1;
      default: fill = b;
    endcase
  end

  assign left_src  = {b, fill};
  assign right_src = {fill, b};
  assign left_sh   = left_src << amt;
  assign right_sh  = right_src >> amt;
  assign y         = go_right ? right_sh[W-1:0] : left_sh[DW-1:W];

  always_comb begin
    if (fn[2:1] == 2'b11) begin
      a_r10_rotate_keeps_ones: assert ($countones(y) == $countones(b));
    end
  end

endmodule

// File: rtl/alu3_top.sv
module alu3_top
  import alu3_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    c_i,
  output logic [W-1:0]    res_o,
  output logic            legal_o
);

  unit_e        unit;
  logic         legal;
  logic [W-1:0] arith_y, logic_y, shift_y, nxt;

  alu3_decode u_dec (
    .op    (op_i),
    .unit  (unit),
    .legal (legal)
  );

  alu3_arith #(.W(W)) u_arith (
    .row1 (op_i[4]),
    .fn   (op_i[3:0]),
    .b    (b_i),
    .c    (c_i),
    .y    (arith_y)
  );

  alu3_logic #(.W(W)) u_logic (
    .fn (op_i[3:0]),
    .b  (b_i),
    .c  (c_i),
    .y  (logic_y)
  );

  alu3_shift #(.W(W), .SH_W(SH_W)) u_shift (
    .fn  (op_i[2:0]),
    .b   (b_i),
    .amt (c_i[SH_W-1:0]),
    .y   (shift_y)
  );

  always_comb begin
    case (unit)
      UNIT_ARITH: nxt = arith_y;
      UNIT_LOGIC: nxt = logic_y;
      UNIT_SHIFT: nxt = shift_y;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      legal_o <= 1'b0;
    end else begin
      res_o   <= nxt;
      legal_o <= legal;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && !legal_o));

  a_r11_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    !legal_o |-> (res_o == '0));

  a_r4_cmp_word_shape: assert property (@(posedge clk) disable iff (rst)
    (legal_o && ($past(op_i) == OP_CMP_S || $past(op_i) == OP_CMP_U))
      |-> (res_o[W-1:3] == '0 && $countones(res_o[2:0]) == 1));

  a_r2_legal_tracks_code: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i[11:8]) != 4'h0) |-> !legal_o);

endmodule

// File: tb/sim_alu3_top.sv
module sim_alu3_top;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   op_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [W-1:0]  c_i = '0;
  logic [W-1:0]  res_o;
  logic          legal_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [11:0]  op;
    logic [W-1:0] res;
    logic         legal;
    string        tag;
  } item_t;

  item_t sb[$];

  alu3_top #(.W(W)) u0 (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .res_o   (res_o),
    .legal_o (legal_o)
  );

  always #4 clk = ~clk;

  function automatic string tag_of(input logic [11:0] op);
    if (op[11:8] != 0) return "R11";
    case (op[7:4])
      4'h0: begin
        if (op[3:0] <= 3) return "R3";
        if (op[3:0] <= 5) return "R4";
        if (op[3:0] <= 9) return "R5";
        return "R11";
      end
      4'h1: return (op[3:0] <= 3) ? "R6" : "R11";
      4'h2: begin
        if (op[3:0] <= 5) return "R7";
        if (op[3:0] <= 9) return "R8";
        return "R11";
      end
      4'h3: begin
        if (op[3:0] <= 5) return "R9";
        if (op[3:0] <= 7) return "R10";
        return "R11";
      end
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W:0] model(input logic [11:0] op,
                                       input logic [W-1:0] b,
                                       input logic [W-1:0] c);
    logic [W-1:0] r;
    logic         ok;
    logic [63:0]  up;
    longint       sp;
    int           k;
    r  = '0;
    ok = 1'b1;
    k  = int'(c[4:0]);
    up = {32'd0, b} * {32'd0, c};
    sp = longint'($signed(b)) * longint'($signed(c));
    case (op)
      12'h000, 12'h001: r = b + c;
      12'h002, 12'h003: r = b - c;
      12'h004: r = ($signed(b) > $signed(c)) ? 1 : ((b == c) ? 2 : 4);
      12'h005: r = (b > c) ? 1 : ((b == c) ? 2 : 4);
      12'h006, 12'h008: r = up[31:0];
      12'h007: r = sp[63:32];
      12'h009: r = up[63:32];
      12'h010: r = ($signed(b) > $signed(c)) ? b : c;
      12'h011: r = (b > c) ? b : c;
      12'h012: r = ($signed(b) < $signed(c)) ? b : c;
      12'h013: r = (b < c) ? b : c;
      12'h020: r = b & c;
      12'h021: r = b | c;
      12'h022: r = b ^ c;
      12'h023: r = ~(b & c);
      12'h024: r = ~(b | c);
      12'h025: r = ~(b ^ c);
      12'h026: r = ~b & c;
      12'h027: r = b & ~c;
      12'h028: r = ~b | c;
      12'h029: r = b | ~c;
      12'h030, 12'h032: r = b << k;
      12'h031: r = $signed(b) >>> k;
      12'h033: r = b >> k;
      12'h034: r = ~((~b) << k);
      12'h035: r = ~((~b) >> k);
      12'h036: r = (k == 0) ? b : ((b << k) | (b >> (32 - k)));
      12'h037: r = (k == 0) ? b : ((b >> k) | (b << (32 - k)));
      default: begin r = '0; ok = 1'b0; end
    endcase
    return {ok, r};
  endfunction

  task automatic drive(input logic [11:0] op, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] er,
                       input logic el, input string tag);
    item_t it;
    @(negedge clk);
    op_i = op; b_i = b; c_i = c;
    it.op = op; it.res = er; it.legal = el; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive_m(input logic [11:0] op, input logic [W-1:0] b,
                         input logic [W-1:0] c);
    logic [W:0] e;
    e = model(op, b, c);
    drive(op, b, c, e[W-1:0], e[W], tag_of(op));
  endtask

  // monitor: compare oldest expectation 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (res_o !== it.res || legal_o !== it.legal) begin
        fails++;
        $display("FAIL %s op=%03h res=%08h exp=%08h legal=%0b exp=%0b",
                 it.tag, it.op, res_o, it.res, legal_o, it.legal);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with a legal add on the inputs
    op_i = 12'h000; b_i = 32'd5; c_i = 32'd7;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (res_o !== '0 || legal_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 res=%08h exp=00000000 legal=%0b exp=0", res_o, legal_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R3 wrap
    drive(12'h001, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1, "R3");
    drive(12'h002, 32'd0, 32'd1, 32'hFFFF_FFFF, 1'b1, "R3");
    // R4 compare word
    drive(12'h004, 32'hFFFF_FFFF, 32'd1, 32'd4, 1'b1, "R4");
    drive(12'h005, 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b1, "R4");
    drive(12'h004, 32'd9, 32'd9, 32'd2, 1'b1, "R4");
    // R5 multiply halves
    drive(12'h007, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1, "R5");
    drive(12'h009, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, "R5");
    drive(12'h006, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 1'b1, "R5");
    // R6 max signedness
    drive(12'h010, 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b1, "R6");
    drive(12'h011, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 1'b1, "R6");
    // R7 and R8 bitwise
    drive(12'h023, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0FFF_0FFF, 1'b1, "R7");
    drive(12'h029, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hFF0F_FF0F, 1'b1, "R8");
    // R9 fills
    drive(12'h034, 32'h0, 32'd4, 32'h0000_000F, 1'b1, "R9");
    drive(12'h035, 32'h0, 32'd4, 32'hF000_0000, 1'b1, "R9");
    drive(12'h031, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF, 1'b1, "R9");
    drive(12'h033, 32'h8000_0000, 32'd31, 32'h1, 1'b1, "R9");
    drive(12'h034, 32'h1234_5678, 32'hFFFF_FFE0, 32'h1234_5678, 1'b1, "R9");
    // R10 rotates
    drive(12'h036, 32'h8000_0001, 32'd1, 32'h0000_0003, 1'b1, "R10");
    drive(12'h037, 32'h0000_0001, 32'd1, 32'h8000_0000, 1'b1, "R10");
    // R11 undefined codes
    drive(12'h00A, 32'd10, 32'd3, 32'h0, 1'b0, "R11");
    drive(12'h038, 32'd10, 32'd3, 32'h0, 1'b0, "R11");
    drive(12'h100, 32'd10, 32'd3, 32'h0, 1'b0, "R11");
    drive(12'hFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, "R11");

    // R2: back-to-back sweep of every code in the first 64, several patterns
    for (int op = 0; op < 64; op++) begin
      drive_m(12'(op), $urandom, $urandom);
      drive_m(12'(op), 32'h8000_0000, 32'h7FFF_FFFF);
      drive_m(12'(op), 32'hFFFF_FFFF, 32'd1);
      drive_m(12'(op), $urandom, 32'd0);
      drive_m(12'(op), $urandom, 32'd31);
    end
    for (int n = 0; n < 40; n++) begin
      drive_m(12'($urandom_range(0, 4095)), $urandom, $urandom);
    end

    repeat (4) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule